// File: doc/BRIEF.md
# Dual-Bank I2C Configuration Target

This block is an I2C target that holds two 256-entry byte banks behind two adjacent 7-bit bus addresses. One bank is volatile and takes each data byte as soon as the byte is received. The other bank stands in for a nonvolatile array. Its data bytes collect in a 16-entry page buffer and are committed together when STOP closes the frame. A commit starts a busy interval, and during that interval the target answers nothing on the bus.

The block works on SCL and SDA after a two-flop synchroniser and a short majority filter, so the system clock must run at least 16 times the SCL rate. SDA is driven open-drain: `sda_oe_o` high means the pad is pulled low. A single byte pointer is shared by both banks. Data writes advance only the pointer's low nibble, which keeps a multi-byte write inside one 16-byte page. Reads advance the whole pointer, so a sequential read wraps inside the bank that was addressed. A write-protect input stops the nonvolatile commit and has no effect on anything else.

Top module: `cfg_bank_i2c_target`

## Requirements
- R1: After reset, SDA is released, `busy_o` is 0, and every entry of both banks reads 0.
- R2: The target acknowledges address byte 0xD0/0xD1 (7-bit address 1101000, nonvolatile bank) and 0xD2/0xD3 (1101001, volatile bank). Bit 0 of the address byte is 1 for read and 0 for write. Any other address is not acknowledged, and SDA stays released until the next START or STOP.
- R3: A write frame is START, address with R/W=0, pointer byte, then data bytes. The target pulls SDA low on the ninth clock of each byte. A volatile data byte is stored at the pointer. SDA changes only while SCL is low.
- R4: After each written byte, only pointer bits [3:0] increment. A 17th byte therefore overwrites the first byte of the frame, and the other bytes wrap to the start of the page.
- R5: A read with no pointer write first returns the entry one past the last entry read or written.
- R6: A random read writes the pointer, sends a repeated START and then R/W=1, and returns that entry. A master ACK sends the next entry. Sequential reads wrap from 0xFF to 0x00 within the addressed bank, and the two banks hold separate data.
- R7: STOP after nonvolatile data bytes commits the page. `busy_o` is then high for exactly COMMIT_CYCLES clocks, and the data reads back afterwards.
- R8: While `wp_i` is 1 at STOP, nonvolatile data bytes are still acknowledged, but no commit happens: `busy_o` stays 0 and the old data remain. Volatile writes are not affected.
- R9: While busy, the target does not acknowledge its address and never drives SDA.
- R10: A master NACK after a read byte ends the transfer, and the target releases SDA for the following clocks.
- R11: A repeated START after nonvolatile data bytes discards those bytes. No commit or busy interval follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line, asynchronous |
| sda_i | input | 1 | Bus data line as seen at the pad, asynchronous |
| wp_i | input | 1 | Write protect for the nonvolatile commit |
| sda_oe_o | output | 1 | Open-drain enable; 1 pulls SDA low |
| busy_o | output | 1 | Nonvolatile commit in progress |

## Verification
The hardest state to reach from the ports is a new frame that arrives inside the commit lockout. The bench sends a nonvolatile write and then, right after STOP, issues an address byte while `busy_o` is still high. It expects a NACK and a released line, then reads the committed bytes back once busy has fallen. Page wrap with a 17th byte, the 0xFF to 0x00 read wrap, and a repeated START that cuts off a pending nonvolatile page are driven as directed cases. A seeded random mix of writes and reads then runs over both banks and both write-protect levels, checked against a bench memory model.

// File: rtl/cfgb_pkg.sv
package cfgb_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE, ST_DEV, ST_REG, ST_WDATA, ST_ACK, ST_RDATA, ST_RACK, ST_IGNORE
  } cfgb_state_e;

  typedef enum logic [1:0] {NX_REG, NX_WDATA, NX_RDATA} cfgb_next_e;
endpackage

// File: rtl/cfgb_line_filter.sv
module cfgb_line_filter #(
  parameter int TAPS = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  output logic line_o
);
  localparam int CW = $clog2(TAPS + 1);

  logic [1:0]      sync_q;
  logic [TAPS-1:0] win_q;
  logic            out_q;
  logic [CW-1:0]   ones;

  always_comb begin
    ones = '0;
    for (int k = 0; k < TAPS; k++) ones = ones + CW'(win_q[k]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '1;
      win_q  <= '1;
      out_q  <= 1'b1;
    end else begin
      sync_q <= {sync_q[0], line_i};
      win_q  <= {win_q[TAPS-2:0], sync_q[1]};
      out_q  <= (ones > CW'(TAPS / 2));
    end
  end

  assign line_o = out_q;
endmodule

// File: rtl/cfgb_commit_timer.sv
module cfgb_commit_timer #(
  parameter int COMMIT_CYCLES = 600
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o
);
  localparam int CW = $clog2(COMMIT_CYCLES + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (start_i)         cnt_q <= CW'(COMMIT_CYCLES);
    else if (cnt_q != '0)     cnt_q <= cnt_q - CW'(1);
  end

  assign busy_o = (cnt_q != '0);

  // R9
  commit_overlap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !busy_o);
endmodule

// File: rtl/cfgb_bank_store.sv
module cfgb_bank_store
  import cfgb_pkg::*;
#(
  parameter int PAGE_W = 4
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [ADDR_W:0]            rd_addr_i,
  output logic [BYTE_W-1:0]          rd_data_o,
  input  logic                       vol_we_i,
  input  logic [ADDR_W-1:0]          vol_addr_i,
  input  logic [BYTE_W-1:0]          vol_data_i,
  input  logic                       commit_i,
  input  logic [ADDR_W-PAGE_W-1:0]   page_i,
  input  logic [(BYTE_W<<PAGE_W)-1:0] page_data_i,
  input  logic [(1<<PAGE_W)-1:0]     valid_i
);
  localparam int PAGE_N  = 1 << PAGE_W;
  localparam int ENTRIES = 2 << ADDR_W;

  logic [BYTE_W-1:0] mem_q [ENTRIES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < ENTRIES; k++) mem_q[k] <= '0;
    end else begin
      if (vol_we_i) mem_q[{1'b1, vol_addr_i}] <= vol_data_i;
      if (commit_i) begin
        for (int k = 0; k < PAGE_N; k++)
          if (valid_i[k]) mem_q[{1'b0, page_i, PAGE_W'(k)}] <= page_data_i[k*BYTE_W +: BYTE_W];
      end
    end
  end

  assign rd_data_o = mem_q[rd_addr_i];

  // R7
  commit_has_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_i |-> (valid_i != '0));
endmodule

// File: rtl/cfgb_bus_fsm.sv
module cfgb_bus_fsm
  import cfgb_pkg::*;
#(
  parameter int          PAGE_W = 4,
  parameter logic [5:0]  DEV_HI = 6'b110100
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        scl_i,
  input  logic                        sda_i,
  input  logic                        wp_i,
  input  logic                        busy_i,
  input  logic [BYTE_W-1:0]           rd_data_i,
  output logic [ADDR_W:0]             rd_addr_o,
  output logic                        vol_we_o,
  output logic [ADDR_W-1:0]           vol_addr_o,
  output logic [BYTE_W-1:0]           vol_data_o,
  output logic                        commit_o,
  output logic [ADDR_W-PAGE_W-1:0]    page_o,
  output logic [(BYTE_W<<PAGE_W)-1:0] page_data_o,
  output logic [(1<<PAGE_W)-1:0]      valid_o,
  output logic                        sda_oe_o
);
  localparam int PAGE_N = 1 << PAGE_W;

  cfgb_state_e             state_q;
  cfgb_next_e              nxt_q;
  logic                    scl_q, sda_q;
  logic [3:0]              cnt_q;
  logic [BYTE_W-1:0]       sh_q, tx_q;
  logic [ADDR_W-1:0]       ptr_q;
  logic                    bank_q;
  logic                    sda_oe_q;
  logic                    vol_we_q, commit_q;
  logic [ADDR_W-1:0]       vol_addr_q;
  logic [BYTE_W-1:0]       vol_data_q;
  logic [ADDR_W-PAGE_W-1:0] page_q;
  logic [BYTE_W-1:0]       buf_q [PAGE_N];
  logic [PAGE_N-1:0]       valid_q;

  logic scl_rise, scl_fall, start_det, stop_det;
  assign scl_rise  =  scl_i & ~scl_q;
  assign scl_fall  = ~scl_i &  scl_q;
  assign start_det =  scl_i & scl_q &  sda_q & ~sda_i;
  assign stop_det  =  scl_i & scl_q & ~sda_q &  sda_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      nxt_q      <= NX_REG;
      cnt_q      <= '0;
      sh_q       <= '0;
      tx_q       <= '0;
      ptr_q      <= '0;
      bank_q     <= 1'b0;
      sda_oe_q   <= 1'b0;
      vol_we_q   <= 1'b0;
      commit_q   <= 1'b0;
      vol_addr_q <= '0;
      vol_data_q <= '0;
      page_q     <= '0;
      valid_q    <= '0;
      for (int k = 0; k < PAGE_N; k++) buf_q[k] <= '0;
    end else begin
      vol_we_q <= 1'b0;
      commit_q <= 1'b0;
      if (commit_q) valid_q <= '0;
      if (start_det) begin
        state_q  <= ST_DEV;
        cnt_q    <= '0;
        sda_oe_q <= 1'b0;
        valid_q  <= '0;           // repeated START drops a pending page
      end else if (stop_det) begin
        state_q  <= ST_IDLE;
        sda_oe_q <= 1'b0;
        if (valid_q != '0) begin
          if (wp_i) valid_q  <= '0;
          else      commit_q <= 1'b1;
        end
      end else begin
        unique case (state_q)
          ST_DEV, ST_REG, ST_WDATA: begin
            if (scl_rise) begin
              sh_q  <= {sh_q[BYTE_W-2:0], sda_i};
              cnt_q <= cnt_q + 4'd1;
            end else if (scl_fall && cnt_q == 4'd8) begin
              cnt_q <= '0;
              if (state_q == ST_DEV) begin
                if (sh_q[7:2] == DEV_HI && !busy_i) begin
                  bank_q   <= sh_q[1];
                  nxt_q    <= sh_q[0] ? NX_RDATA : NX_REG;
                  sda_oe_q <= 1'b1;
                  state_q  <= ST_ACK;
                end else begin
                  state_q  <= ST_IGNORE;
                end
              end else if (state_q == ST_REG) begin
                ptr_q    <= sh_q[ADDR_W-1:0];
                nxt_q    <= NX_WDATA;
                sda_oe_q <= 1'b1;
                state_q  <= ST_ACK;
              end else begin
                if (bank_q) begin
                  vol_we_q   <= 1'b1;
                  vol_addr_q <= ptr_q;
                  vol_data_q <= sh_q;
                end else begin
                  buf_q[ptr_q[PAGE_W-1:0]]   <= sh_q;
                  valid_q[ptr_q[PAGE_W-1:0]] <= 1'b1;
                  page_q <= ptr_q[ADDR_W-1:PAGE_W];
                end
                ptr_q    <= {ptr_q[ADDR_W-1:PAGE_W], ptr_q[PAGE_W-1:0] + PAGE_W'(1)};
                nxt_q    <= NX_WDATA;
                sda_oe_q <= 1'b1;
                state_q  <= ST_ACK;
              end
            end
          end
          ST_ACK: begin
            if (scl_fall) begin
              cnt_q <= '0;
              if (nxt_q == NX_RDATA) begin
                tx_q     <= rd_data_i;
                ptr_q    <= ptr_q + ADDR_W'(1);
                sda_oe_q <= ~rd_data_i[BYTE_W-1];
                state_q  <= ST_RDATA;
              end else begin
                sda_oe_q <= 1'b0;
                state_q  <= (nxt_q == NX_REG) ? ST_REG : ST_WDATA;
              end
            end
          end
          ST_RDATA: begin
            if (scl_rise) begin
              cnt_q <= cnt_q + 4'd1;
            end else if (scl_fall) begin
              if (cnt_q == 4'd8) begin
                sda_oe_q <= 1'b0;
                state_q  <= ST_RACK;
              end else begin
                sda_oe_q <= ~tx_q[3'(4'd7 - cnt_q)];
              end
            end
          end
          ST_RACK: begin
            if (scl_rise) begin
              if (sda_i) state_q <= ST_IGNORE;
              else begin
                nxt_q   <= NX_RDATA;
                state_q <= ST_ACK;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  for (genvar g = 0; g < PAGE_N; g++) begin : g_flat
    assign page_data_o[g*BYTE_W +: BYTE_W] = buf_q[g];
  end

  assign rd_addr_o  = {bank_q, ptr_q};
  assign vol_we_o   = vol_we_q;
  assign vol_addr_o = vol_addr_q;
  assign vol_data_o = vol_data_q;
  assign commit_o   = commit_q;
  assign page_o     = page_q;
  assign valid_o    = valid_q;
  assign sda_oe_o   = sda_oe_q;

  // R3
  sda_low_phase_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sda_oe_q != $past(sda_oe_q)) |-> !$past(scl_i));
  // R9
  busy_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |-> !sda_oe_q);
  // R8
  wp_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_q |-> !$past(wp_i));
endmodule

// File: rtl/cfg_bank_i2c_target.sv
module cfg_bank_i2c_target
  import cfgb_pkg::*;
#(
  parameter int         PAGE_W        = 4,
  parameter int         FILT_TAPS     = 3,
  parameter int         COMMIT_CYCLES = 600,
  parameter logic [5:0] DEV_HI        = 6'b110100
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  input  logic wp_i,
  output logic sda_oe_o,
  output logic busy_o
);
  localparam int PAGE_N = 1 << PAGE_W;

  logic [1:0] raw, filt;
  assign raw = {sda_i, scl_i};

  for (genvar g = 0; g < 2; g++) begin : g_line
    cfgb_line_filter #(.TAPS(FILT_TAPS)) u_filt (
      .clk_i (clk_i), .rst_ni(rst_ni), .line_i(raw[g]), .line_o(filt[g])
    );
  end

  logic [ADDR_W:0]            rd_addr;
  logic [BYTE_W-1:0]          rd_data;
  logic                       vol_we, commit;
  logic [ADDR_W-1:0]          vol_addr;
  logic [BYTE_W-1:0]          vol_data;
  logic [ADDR_W-PAGE_W-1:0]   page;
  logic [BYTE_W*PAGE_N-1:0]   page_data;
  logic [PAGE_N-1:0]          valid;
  logic                       busy;

  cfgb_bus_fsm #(.PAGE_W(PAGE_W), .DEV_HI(DEV_HI)) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (filt[0]),
    .sda_i      (filt[1]),
    .wp_i       (wp_i),
    .busy_i     (busy),
    .rd_data_i  (rd_data),
    .rd_addr_o  (rd_addr),
    .vol_we_o   (vol_we),
    .vol_addr_o (vol_addr),
    .vol_data_o (vol_data),
    .commit_o   (commit),
    .page_o     (page),
    .page_data_o(page_data),
    .valid_o    (valid),
    .sda_oe_o   (sda_oe_o)
  );

  cfgb_bank_store #(.PAGE_W(PAGE_W)) u_store (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_addr_i  (rd_addr),
    .rd_data_o  (rd_data),
    .vol_we_i   (vol_we),
    .vol_addr_i (vol_addr),
    .vol_data_i (vol_data),
    .commit_i   (commit),
    .page_i     (page),
    .page_data_i(page_data),
    .valid_i    (valid)
  );

  cfgb_commit_timer #(.COMMIT_CYCLES(COMMIT_CYCLES)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(commit),
    .busy_o (busy)
  );

  assign busy_o = busy;
endmodule

// File: tb/sim_cfg_bank_i2c_target.sv
module sim_cfg_bank_i2c_target;
  localparam int Q      = 8;
  localparam int COMMIT = 600;
  localparam logic [5:0] DEV = 6'b110100;

  logic clk = 1'b0, rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1, m_wp = 1'b0;
  logic sda_oe, busy;
  logic sda_line;
  assign sda_line = m_sda & ~sda_oe;

  always #2 clk = ~clk;

  cfg_bank_i2c_target #(.COMMIT_CYCLES(COMMIT)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(m_scl), .sda_i(sda_line),
    .wp_i(m_wp), .sda_oe_o(sda_oe), .busy_o(busy)
  );

  int checks = 0, failures = 0, busy_cnt = 0;
  logic [7:0] ref_mem [512];
  logic [7:0] ref_ptr = 8'h00;
  logic [7:0] wbuf [20];

  always @(negedge clk) if (busy) busy_cnt++;

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] page_next(input logic [7:0] p);
    return {p[7:4], p[3:0] + 4'd1};
  endfunction

  task automatic hp(); repeat (Q) @(negedge clk); endtask
  task automatic bus_start(); m_sda = 1; hp(); m_scl = 1; hp(); m_sda = 0; hp(); m_scl = 0; hp(); endtask
  task automatic bus_stop(); m_sda = 0; hp(); m_scl = 1; hp(); m_sda = 1; hp(); hp(); endtask
  task automatic clk_bit(input logic b, output logic r);
    m_sda = b; hp(); m_scl = 1; hp(); r = sda_line; hp(); m_scl = 0; hp();
  endtask
  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic r;
    for (int i = 7; i >= 0; i--) clk_bit(b[i], r);
    clk_bit(1'b1, r);
    ack = ~r;
  endtask
  task automatic recv_byte(input logic mack, output logic [7:0] b);
    logic r;
    for (int i = 7; i >= 0; i--) begin clk_bit(1'b1, r); b[i] = r; end
    clk_bit(~mack, r);
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  // write frame; model applies nonvolatile page only on STOP without WP
  task automatic wr_frame(input logic bank, input logic [7:0] a, input int n,
                          input logic do_stop, output logic ok);
    logic ack; logic [7:0] p; logic [7:0] pend [16]; logic [15:0] pv;
    ok = 1; pv = '0; p = a;
    bus_start();
    send_byte({DEV, bank, 1'b0}, ack); ok &= ack;
    send_byte(a, ack); ok &= ack;
    for (int i = 0; i < n; i++) begin
      send_byte(wbuf[i], ack); ok &= ack;
      if (bank) ref_mem[{1'b1, p}] = wbuf[i];
      else begin pend[p[3:0]] = wbuf[i]; pv[p[3:0]] = 1'b1; end
      p = page_next(p);
    end
    ref_ptr = p;
    if (do_stop) begin
      bus_stop();
      if (!bank && !m_wp)
        for (int k = 0; k < 16; k++) if (pv[k]) ref_mem[{1'b0, a[7:4], 4'(k)}] = pend[k];
    end
  endtask

  task automatic rd_frame(input logic bank, input logic [7:0] a, input int n,
                          input logic set_ptr, input string req);
    logic ack; logic [7:0] b;
    if (set_ptr) begin
      bus_start();
      send_byte({DEV, bank, 1'b0}, ack);
      send_byte(a, ack);
      ref_ptr = a;
    end
    bus_start();
    send_byte({DEV, bank, 1'b1}, ack);
    chk(ack, req, ack, 1);
    for (int i = 0; i < n; i++) begin
      recv_byte(i < n - 1, b);
      chk(b == ref_mem[{bank, ref_ptr}], req, b, ref_mem[{bank, ref_ptr}]);
      ref_ptr = ref_ptr + 8'd1;
    end
    bus_stop();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 190000, 0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic ok, ack, r; logic [7:0] b;
    void'($urandom(32'd4177));
    for (int k = 0; k < 512; k++) ref_mem[k] = 8'h00;
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (10) @(negedge clk);

    // R1 reset state
    chk(sda_oe == 1'b0, "R1 sda released", sda_oe, 0);
    chk(busy == 1'b0, "R1 busy low", busy, 0);
    rd_frame(1'b1, 8'h00, 1, 1'b1, "R1 volatile cleared");

    // R3 single volatile write then random read
    wbuf[0] = 8'h3C;
    wr_frame(1'b1, 8'h10, 1, 1'b1, ok);
    chk(ok, "R3 write acks", ok, 1);
    rd_frame(1'b1, 8'h10, 1, 1'b1, "R3 readback");

    // R5 current address read
    wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33;
    wr_frame(1'b1, 8'h20, 3, 1'b1, ok);
    rd_frame(1'b1, 8'h20, 1, 1'b1, "R6 random read");
    rd_frame(1'b1, 8'h00, 2, 1'b0, "R5 current address");
    chk(ref_mem[{1'b1, 8'h21}] == 8'h22, "R5 model", ref_mem[{1'b1, 8'h21}], 8'h22);

    // R4 17-byte page wrap
    for (int i = 0; i < 17; i++) wbuf[i] = 8'(8'h80 + i);
    wr_frame(1'b1, 8'h35, 17, 1'b1, ok);
    chk(ok, "R4 all acked", ok, 1);
    chk(ref_mem[{1'b1, 8'h35}] == 8'h90, "R4 model overwrite", ref_mem[{1'b1, 8'h35}], 8'h90);
    rd_frame(1'b1, 8'h30, 16, 1'b1, "R4 page wrap");

    // R6 sequential wrap and bank separation
    wbuf[0] = 8'h5A; wr_frame(1'b1, 8'hFF, 1, 1'b1, ok);
    wbuf[0] = 8'hA5; wr_frame(1'b1, 8'h00, 1, 1'b1, ok);
    rd_frame(1'b1, 8'hFF, 2, 1'b1, "R6 wrap 0xFF to 0x00");
    rd_frame(1'b0, 8'hFF, 2, 1'b1, "R6 other bank separate");

    // R2 foreign addresses
    bus_start(); send_byte(8'hA0, ack); chk(!ack, "R2 foreign nack", ack, 0);
    send_byte(8'h00, ack); chk(!ack, "R2 stays released", ack, 0);
    bus_stop();
    bus_start(); send_byte(8'hD4, ack); chk(!ack, "R2 near address nack", ack, 0);
    bus_stop();

    // R7 nonvolatile commit and busy length
    busy_cnt = 0;
    wbuf[0] = 8'hC1; wbuf[1] = 8'hC2; wbuf[2] = 8'hC3;
    wr_frame(1'b0, 8'h40, 3, 1'b1, ok);
    chk(ok, "R7 acks", ok, 1);
    wait_idle();
    chk(busy_cnt == COMMIT, "R7 busy length", busy_cnt, COMMIT);
    rd_frame(1'b0, 8'h40, 3, 1'b1, "R7 committed data");

    // R9 lockout
    wbuf[0] = 8'h77;
    wr_frame(1'b0, 8'h48, 1, 1'b1, ok);
    bus_start(); send_byte({DEV, 1'b1, 1'b1}, ack);
    chk(!ack, "R9 nack while busy", ack, 0);
    chk(busy == 1'b1, "R9 still busy", busy, 1);
    bus_stop();
    wait_idle();
    rd_frame(1'b0, 8'h48, 1, 1'b1, "R9 data after busy");

    // R8 write protect
    m_wp = 1; busy_cnt = 0;
    wbuf[0] = 8'hEE; wbuf[1] = 8'hDD;
    wr_frame(1'b0, 8'h40, 2, 1'b1, ok);
    chk(ok, "R8 acks under WP", ok, 1);
    repeat (40) @(negedge clk);
    chk(busy_cnt == 0, "R8 no busy", busy_cnt, 0);
    rd_frame(1'b0, 8'h40, 2, 1'b1, "R8 old data kept");
    wbuf[0] = 8'h6B;
    wr_frame(1'b1, 8'h50, 1, 1'b1, ok);
    rd_frame(1'b1, 8'h50, 1, 1'b1, "R8 volatile unaffected");
    m_wp = 0;

    // R10 master NACK ends transfer
    bus_start(); send_byte({DEV, 1'b1, 1'b0}, ack); send_byte(8'h10, ack);
    bus_start(); send_byte({DEV, 1'b1, 1'b1}, ack);
    recv_byte(1'b0, b);
    chk(b == 8'h3C, "R10 byte", b, 8'h3C);
    for (int i = 0; i < 3; i++) begin
      clk_bit(1'b1, r);
      chk(r == 1'b1, "R10 released", r, 1);
    end
    bus_stop();

    // R11 repeated START drops pending page
    busy_cnt = 0;
    wbuf[0] = 8'h99; wbuf[1] = 8'h98;
    wr_frame(1'b0, 8'h60, 2, 1'b0, ok);
    rd_frame(1'b0, 8'h00, 1, 1'b0, "R11 read after restart");
    repeat (40) @(negedge clk);
    chk(busy_cnt == 0, "R11 no commit", busy_cnt, 0);
    rd_frame(1'b0, 8'h60, 2, 1'b1, "R11 data unchanged");

    // random mix
    for (int it = 0; it < 8; it++) begin
      logic bk; logic [7:0] a; int n;
      bk = 1'($urandom);
      m_wp = (($urandom % 4) == 0);
      a = 8'($urandom);
      n = 1 + int'($urandom % 8);
      for (int i = 0; i < n; i++) wbuf[i] = 8'($urandom);
      wr_frame(bk, a, n, 1'b1, ok);
      chk(ok, "R3 random write acks", ok, 1);
      wait_idle();
      m_wp = 0;
      rd_frame(bk, {a[7:4], 4'(a[3:0] + 4'($urandom % 4))}, 1 + int'($urandom % 8), 1'b1, "R6 random read");
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule